// File: doc/BRIEF.md
# Extended Attribute Fetch Substitution

This block sits between a video fetch engine and the memories behind it. Every video read passes through it. When the per-tile attribute mode is on, it rewrites the three reads that follow each nametable fetch. The first of these reads returns a palette byte taken from a 1 KB expansion store. The next two return pattern data from a 4 KB pattern bank that comes from the same store byte. Nametable reads, and all reads made while the mode is off, go to the normal video memory unchanged.

The CPU reaches the expansion store through its own write port and its own read port. A 2-bit mode selects what the CPU may do: in modes 0 and 1 it may only write, in mode 2 it may read and write, and in mode 3 it may only read.

The video read path is a valid-only stream. A strobe `vid_rd` carries `vid_addr` in. One cycle later `vid_rvalid` comes back with `vid_rdata`. There is no ready signal, because a video fetch cannot be stalled. The memories on the downstream side must return read data in the same cycle as the strobe. The CPU read path works the same way: one request cycle, then one cycle of `cpu_rvalid`.

Top module: `ext_attr_subst`

## Requirements
- R1: After reset, `vid_rvalid` and `cpu_rvalid` are 0 and the three-read substitution sequence is idle, so an attribute read passes through to `norm_rd`.
- R2: A nametable fetch is a video read with address bits 13:12 = 2'b10 and address bits 9:0 below 0x3C0. It is forwarded to the normal memory with the same address. Its data appears on `vid_rdata` with `vid_rvalid` = 1 in the cycle after the strobe.
- R3: In the active condition, the first non-nametable read after a nametable fetch returns {p,p,p,p}. Here p is bits 7:6 of the store byte at the fetch's address bits 9:0.
- R4: The second and third such reads assert `pat_rd` with `pat_addr` = {bank, vid_addr[11:0]} and return `pat_rdata`. The bank is {upper_bank, store byte bits 5:0}, which is 8 bits. The normal memory is not read for these two reads.
- R5: After the third rewritten read, further non-nametable reads pass through to the normal memory until the next nametable fetch.
- R6: The active condition requires `mode` = 1 and `in_frame` = 1. In any other mode, or with `in_frame` = 0, all reads pass through.
- R7: A tile counter counts nametable fetches since the last `line_start` pulse, including the current fetch. While it is in the range 32 to 39 (the sprite window), no substitution happens and no sequence starts. `line_start` clears the counter.
- R8: A CPU read returns data one cycle later with `cpu_rvalid` = 1. In modes 0 and 1 it gives `cpu_open` = 1 and `cpu_rdata` = 0. In modes 2 and 3 it gives `cpu_open` = 0 and the stored byte.
- R9: A CPU write in mode 2 stores the written byte. In mode 3 it is ignored.
- R10: A CPU write in mode 0 or 1 stores the written byte while `in_frame` = 1, and stores 0 while `in_frame` = 0.
- R11: The pattern bank is captured when the palette read takes place. A change of `upper_bank` after that point does not alter the two pattern reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Expansion store mode |
| in_frame | input | 1 | Rendering-active flag |
| upper_bank | input | 2 | Upper bits of the substituted pattern bank |
| line_start | input | 1 | Scanline start pulse; clears the tile counter |
| vid_rd | input | 1 | Video read strobe |
| vid_addr | input | 14 | Video read address |
| vid_rvalid | output | 1 | Video read data valid |
| vid_rdata | output | 8 | Video read data |
| norm_rd | output | 1 | Read strobe to the normal video memory |
| norm_addr | output | 14 | Address to the normal video memory |
| norm_rdata | input | 8 | Data from the normal video memory, same cycle |
| pat_rd | output | 1 | Read strobe to the pattern memory |
| pat_addr | output | 20 | Substituted pattern address |
| pat_rdata | input | 8 | Data from the pattern memory, same cycle |
| cpu_wr | input | 1 | CPU write strobe to the store |
| cpu_rd | input | 1 | CPU read strobe to the store |
| cpu_addr | input | 10 | CPU store address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | 8 | CPU read data (0 when not readable) |
| cpu_open | output | 1 | CPU read was refused in modes 0 and 1 |

## Verification
The assertions check the following on every cycle:
- each read strobe is answered one cycle later;
- the normal and pattern strobes are never both high;
- pattern reads happen only in mode 1 while rendering, and keep the low 12 address bits;
- pattern data is carried unchanged to the video output;
- nametable fetches always reach the normal memory;
- CPU reads in modes 0 and 1 are refused.

Other behaviours need a sequence of stimulus, so only the bench scenarios can show them:
- the palette replication and the bank value, which depend on store contents;
- the sequence stopping after three reads;
- the sprite window counted from `line_start`;
- the zero-store rule and the ignored writes, which can only be seen by reading back through the CPU port.

// File: rtl/exattr_pkg.sv
package exattr_pkg;
  typedef enum logic [1:0] {
    SRC_NORM = 2'd0,
    SRC_PAL  = 2'd1,
    SRC_PAT  = 2'd2
  } src_e;

  localparam logic [1:0] MODE_EXT_ATTR = 2'd1;
  localparam logic [1:0] MODE_RW       = 2'd2;
  localparam logic [1:0] MODE_RO       = 2'd3;
endpackage

// File: rtl/exattr_store.sv
module exattr_store
  import exattr_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          in_frame,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_open,
  input  logic [AW-1:0] vr_addr,
  output logic [DW-1:0] vr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          wr_allowed;
  logic          wr_zeroed;
  logic [DW-1:0] wr_value;
  logic          rd_allowed;

  // Modes 0/1 are write-only; mode 3 is read-only.
  assign wr_allowed = (mode != MODE_RO);
  assign wr_zeroed  = !mode[1] && !in_frame;
  assign wr_value   = wr_zeroed ? '0 : cpu_wdata;
  assign rd_allowed = mode[1];

  always_ff @(posedge clk) begin
    if (cpu_wr && wr_allowed) mem[cpu_addr] <= wr_value;
  end

  assign vr_data = mem[vr_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      cpu_open   <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_rd;
      if (cpu_rd) begin
        cpu_open  <= !rd_allowed;
        cpu_rdata <= rd_allowed ? mem[cpu_addr] : '0;
      end
    end
  end
endmodule

// File: rtl/exattr_tracker.sv
module exattr_tracker
  import exattr_pkg::*;
#(
  parameter int VA_W       = 14,
  parameter int DW         = 8,
  parameter int RAM_AW     = 10,
  parameter int UP_W       = 2,
  parameter int TC_W       = 7,
  parameter int SEQ_LEN    = 3,
  parameter int ATTR_START = 'h3C0,
  parameter int SPR_FIRST  = 32,
  parameter int SPR_END    = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vid_rd,
  input  logic [VA_W-1:0]        vid_addr,
  input  logic                   line_start,
  input  logic [1:0]             mode,
  input  logic                   in_frame,
  input  logic [UP_W-1:0]        upper_bank,
  input  logic [DW-1:0]          ram_byte,
  output logic [RAM_AW-1:0]      ram_off,
  output src_e                   src,
  output logic [UP_W+DW-3:0]     bank
);
  localparam int FC_W   = $clog2(SEQ_LEN + 1);
  localparam int BANK_W = UP_W + DW - 2;
  localparam logic [TC_W-1:0] TC_MAX = '1;
  localparam logic [FC_W-1:0] FC_LOAD = FC_W'(SEQ_LEN);

  logic [TC_W-1:0] tcnt;
  logic [TC_W-1:0] tile_eff;
  logic [FC_W-1:0] fcnt;
  logic            is_nt;
  logic            in_window;
  logic            active;

  assign is_nt = (vid_addr[VA_W-1 -: 2] == 2'b10) &&
                 (vid_addr[RAM_AW-1:0] < RAM_AW'(ATTR_START));

  always_comb begin
    tile_eff = tcnt;
    if (is_nt && tcnt != TC_MAX) tile_eff = tcnt + 1'b1;
  end

  assign in_window = (tile_eff < TC_W'(SPR_FIRST)) || (tile_eff >= TC_W'(SPR_END));
  assign active    = vid_rd && (mode == MODE_EXT_ATTR) && in_frame && in_window;

  always_comb begin
    src = SRC_NORM;
    if (active && !is_nt && fcnt != '0) src = (fcnt == FC_LOAD) ? SRC_PAL : SRC_PAT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt    <= '0;
      fcnt    <= '0;
      ram_off <= '0;
      bank    <= '0;
    end else begin
      if (line_start)                  tcnt <= '0;
      else if (vid_rd && is_nt)        tcnt <= tile_eff;
      if (active && is_nt) begin
        ram_off <= vid_addr[RAM_AW-1:0];
        fcnt    <= FC_LOAD;
      end else if (active && fcnt != '0) begin
        fcnt <= fcnt - 1'b1;
        if (fcnt == FC_LOAD) bank <= BANK_W'({upper_bank, ram_byte[DW-3:0]});
      end
    end
  end
endmodule

// File: rtl/exattr_rdmux.sv
module exattr_rdmux
  import exattr_pkg::*;
#(
  parameter int VA_W      = 14,
  parameter int DW        = 8,
  parameter int BANK_W    = 8,
  parameter int PAT_OFF_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          vid_rd,
  input  logic [VA_W-1:0]               vid_addr,
  input  src_e                          src,
  input  logic [BANK_W-1:0]             bank,
  input  logic [DW-1:0]                 ram_byte,
  input  logic [DW-1:0]                 norm_rdata,
  input  logic [DW-1:0]                 pat_rdata,
  output logic                          norm_rd,
  output logic [VA_W-1:0]               norm_addr,
  output logic                          pat_rd,
  output logic [BANK_W+PAT_OFF_W-1:0]   pat_addr,
  output logic                          vid_rvalid,
  output logic [DW-1:0]                 vid_rdata
);
  localparam int REPS = DW / 2;

  logic [DW-1:0] pal_byte;
  logic [DW-1:0] sel_data;

  // Copy the palette bits into every 2-bit field of the byte.
  genvar g;
  generate
    for (g = 0; g < REPS; g++) begin : g_pal
      assign pal_byte[2*g +: 2] = ram_byte[DW-1 -: 2];
    end
  endgenerate

  assign norm_rd   = vid_rd && (src == SRC_NORM);
  assign norm_addr = vid_addr;
  assign pat_rd    = vid_rd && (src == SRC_PAT);
  assign pat_addr  = {bank, vid_addr[PAT_OFF_W-1:0]};

  always_comb begin
    unique case (src)
      SRC_PAL: sel_data = pal_byte;
      SRC_PAT: sel_data = pat_rdata;
      default: sel_data = norm_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_rvalid <= 1'b0;
      vid_rdata  <= '0;
    end else begin
      vid_rvalid <= vid_rd;
      if (vid_rd) vid_rdata <= sel_data;
    end
  end
endmodule

// File: rtl/ext_attr_subst.sv
module ext_attr_subst
  import exattr_pkg::*;
#(
  parameter int VA_W      = 14,
  parameter int DW        = 8,
  parameter int RAM_AW    = 10,
  parameter int UP_W      = 2,
  parameter int PAT_OFF_W = 12,
  parameter int TC_W      = 7,
  localparam int BANK_W   = UP_W + DW - 2,
  localparam int PAT_AW   = BANK_W + PAT_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              in_frame,
  input  logic [UP_W-1:0]   upper_bank,
  input  logic              line_start,
  input  logic              vid_rd,
  input  logic [VA_W-1:0]   vid_addr,
  output logic              vid_rvalid,
  output logic [DW-1:0]     vid_rdata,
  output logic              norm_rd,
  output logic [VA_W-1:0]   norm_addr,
  input  logic [DW-1:0]     norm_rdata,
  output logic              pat_rd,
  output logic [PAT_AW-1:0] pat_addr,
  input  logic [DW-1:0]     pat_rdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [RAM_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_open
);
  logic [RAM_AW-1:0] ram_off;
  logic [DW-1:0]     ram_byte;
  logic [BANK_W-1:0] bank;
  src_e              src;

  exattr_store #(.AW(RAM_AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_frame(in_frame),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_open(cpu_open),
    .vr_addr(ram_off), .vr_data(ram_byte)
  );

  exattr_tracker #(.VA_W(VA_W), .DW(DW), .RAM_AW(RAM_AW), .UP_W(UP_W), .TC_W(TC_W)) u_track (
    .clk(clk), .rst_n(rst_n), .vid_rd(vid_rd), .vid_addr(vid_addr),
    .line_start(line_start), .mode(mode), .in_frame(in_frame),
    .upper_bank(upper_bank), .ram_byte(ram_byte),
    .ram_off(ram_off), .src(src), .bank(bank)
  );

  exattr_rdmux #(.VA_W(VA_W), .DW(DW), .BANK_W(BANK_W), .PAT_OFF_W(PAT_OFF_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .vid_rd(vid_rd), .vid_addr(vid_addr),
    .src(src), .bank(bank), .ram_byte(ram_byte),
    .norm_rdata(norm_rdata), .pat_rdata(pat_rdata),
    .norm_rd(norm_rd), .norm_addr(norm_addr), .pat_rd(pat_rd), .pat_addr(pat_addr),
    .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata)
  );
endmodule

// File: rtl/ext_attr_subst_chk.sv
module ext_attr_subst_chk #(
  parameter int VA_W = 14,
  parameter int DW   = 8,
  parameter int PAT_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              in_frame,
  input logic              vid_rd,
  input logic [VA_W-1:0]   vid_addr,
  input logic              vid_rvalid,
  input logic [DW-1:0]     vid_rdata,
  input logic              norm_rd,
  input logic [VA_W-1:0]   norm_addr,
  input logic              pat_rd,
  input logic [PAT_AW-1:0] pat_addr,
  input logic [DW-1:0]     pat_rdata,
  input logic              cpu_rd,
  input logic              cpu_rvalid,
  input logic              cpu_open
);
  logic nt_fetch;
  assign nt_fetch = (vid_addr[VA_W-1 -: 2] == 2'b10) && (vid_addr[9:0] < 10'h3C0);

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vid_rd |=> vid_rvalid);

  assert_nt_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_rd && nt_fetch) |-> (norm_rd && norm_addr == vid_addr));

  assert_one_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({norm_rd, pat_rd}));

  assert_pat_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rd |-> (pat_addr[11:0] == vid_addr[11:0]));

  assert_pat_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rd |=> (vid_rvalid && vid_rdata == $past(pat_rdata)));

  assert_pat_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rd |-> (mode == 2'd1 && in_frame));

  assert_cpu_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !mode[1]) |=> (cpu_rvalid && cpu_open));

  assert_cpu_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |=> cpu_rvalid);
endmodule

bind ext_attr_subst ext_attr_subst_chk #(.VA_W(VA_W), .DW(DW), .PAT_AW(PAT_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .in_frame(in_frame),
  .vid_rd(vid_rd), .vid_addr(vid_addr), .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata),
  .norm_rd(norm_rd), .norm_addr(norm_addr), .pat_rd(pat_rd), .pat_addr(pat_addr),
  .pat_rdata(pat_rdata), .cpu_rd(cpu_rd), .cpu_rvalid(cpu_rvalid), .cpu_open(cpu_open)
);

// File: tb/ext_attr_subst_tb.sv
`timescale 1ns/1ps
module ext_attr_subst_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        in_frame = 1'b0;
  logic [1:0]  upper_bank = 2'd0;
  logic        line_start = 1'b0;
  logic        vid_rd = 1'b0;
  logic [13:0] vid_addr = '0;
  logic        vid_rvalid;
  logic [7:0]  vid_rdata;
  logic        norm_rd;
  logic [13:0] norm_addr;
  logic [7:0]  norm_rdata;
  logic        pat_rd;
  logic [19:0] pat_addr;
  logic [7:0]  pat_rdata;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [9:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [7:0]  cpu_rdata;
  logic        cpu_open;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // Memory models behind the block.
  assign norm_rdata = norm_addr[7:0] ^ 8'h5A;
  assign pat_rdata  = pat_addr[7:0] ^ pat_addr[19:12];

  ext_attr_subst u_dut (.*);

  function automatic logic [7:0] nmodel(input logic [13:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] pmodel(input logic [19:0] a);
    return a[7:0] ^ a[19:12];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic vread(input logic [13:0] a, output logic [7:0] d, output logic v,
                       output logic prd, output logic [19:0] pa);
    vid_rd = 1'b1; vid_addr = a;
    #1;
    prd = pat_rd; pa = pat_addr;
    @(negedge clk);
    vid_rd = 1'b0;
    d = vid_rdata; v = vid_rvalid;
  endtask

  task automatic cwrite(input logic [9:0] a, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cread(input logic [9:0] a, output logic [7:0] d, output logic op, output logic v);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata; op = cpu_open; v = cpu_rvalid;
  endtask

  task automatic pulse_line();
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic v, prd; logic [19:0] pa;
    chk("R1 vid_rvalid at reset", vid_rvalid, 0);
    chk("R1 cpu_rvalid at reset", cpu_rvalid, 0);
    mode = 2'd1; in_frame = 1'b1;
    vread(14'h23C5, d, v, prd, pa);
    chk("R1 idle attr read pat_rd", prd, 0);
    chk("R1 idle attr read data", d, nmodel(14'h23C5));
    in_frame = 1'b0; mode = 2'd0;
  endtask

  task automatic t_cpu_port();
    logic [7:0] d; logic op, v;
    mode = 2'd2;
    cwrite(10'h005, 8'hC7);
    cread(10'h005, d, op, v);
    chk("R9 mode2 write readback", d, 8'hC7);
    chk("R8 mode2 rvalid", v, 1);
    chk("R8 mode2 not open", op, 0);
    mode = 2'd3;
    cwrite(10'h005, 8'h11);
    cread(10'h005, d, op, v);
    chk("R9 mode3 write ignored", d, 8'hC7);
    chk("R8 mode3 readable", op, 0);
    mode = 2'd0;
    cread(10'h005, d, op, v);
    chk("R8 mode0 open", op, 1);
    chk("R8 mode0 data zero", d, 0);
    mode = 2'd1; in_frame = 1'b0;
    cwrite(10'h006, 8'hAB);
    mode = 2'd2;
    cread(10'h006, d, op, v);
    chk("R10 write outside frame stores zero", d, 0);
    mode = 2'd1; in_frame = 1'b1;
    cwrite(10'h006, 8'hAB);
    in_frame = 1'b0; mode = 2'd2;
    cread(10'h006, d, op, v);
    chk("R10 write in frame stores data", d, 8'hAB);
  endtask

  task automatic t_subst();
    logic [7:0] d; logic v, prd; logic [19:0] pa;
    mode = 2'd2;
    cwrite(10'h045, 8'h9B);
    mode = 2'd1; in_frame = 1'b1; upper_bank = 2'b10;
    pulse_line();
    vread(14'h2045, d, v, prd, pa);
    chk("R2 nt fetch data", d, nmodel(14'h2045));
    chk("R2 nt fetch valid", v, 1);
    vread(14'h23D1, d, v, prd, pa);
    chk("R3 palette byte", d, 8'hAA);
    upper_bank = 2'b01;
    vread(14'h0123, d, v, prd, pa);
    chk("R4 first pattern strobe", prd, 1);
    chk("R11 bank held after upper change", pa, 20'h9B123);
    chk("R4 first pattern data", d, pmodel(20'h9B123));
    vread(14'h012B, d, v, prd, pa);
    chk("R4 second pattern addr", pa, 20'h9B12B);
    chk("R4 second pattern data", d, pmodel(20'h9B12B));
    vread(14'h0130, d, v, prd, pa);
    chk("R5 fourth read no pattern", prd, 0);
    chk("R5 fourth read normal data", d, nmodel(14'h0130));
  endtask

  task automatic t_mode_gate();
    logic [7:0] d; logic v, prd; logic [19:0] pa;
    mode = 2'd2; in_frame = 1'b1;
    vread(14'h2045, d, v, prd, pa);
    vread(14'h23C1, d, v, prd, pa);
    chk("R6 mode2 attr passes", d, nmodel(14'h23C1));
    mode = 2'd1; in_frame = 1'b0;
    vread(14'h2045, d, v, prd, pa);
    vread(14'h23C2, d, v, prd, pa);
    chk("R6 out of frame attr passes", d, nmodel(14'h23C2));
    vread(14'h0040, d, v, prd, pa);
    chk("R6 out of frame no pattern", prd, 0);
  endtask

  task automatic t_window();
    logic [7:0] d; logic v, prd; logic [19:0] pa;
    mode = 2'd1; in_frame = 1'b1;
    pulse_line();
    for (int i = 1; i <= 31; i++) vread(14'h2000 + 14'(i), d, v, prd, pa);
    vread(14'h2045, d, v, prd, pa);
    vread(14'h23C3, d, v, prd, pa);
    chk("R7 tile 32 attr passes", d, nmodel(14'h23C3));
    for (int i = 33; i <= 39; i++) vread(14'h2000 + 14'(i), d, v, prd, pa);
    vread(14'h2845, d, v, prd, pa);
    vread(14'h2BC4, d, v, prd, pa);
    chk("R7 tile 40 attr substituted", d, 8'hAA);
    pulse_line();
    vread(14'h2C45, d, v, prd, pa);
    vread(14'h2FC0, d, v, prd, pa);
    chk("R7 line start clears count", d, 8'hAA);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cpu_port();
    t_subst();
    t_mode_gate();
    t_window();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic t_reset_pre();
    chk("R1 vid_rvalid in reset", vid_rvalid, 0);
  endtask
endmodule